// File: doc/BRIEF.md
# Window Watchdog with Early Warning

This block supervises software timing. A 7-bit down-counter is stepped by a prescaled copy of the bus clock once software arms it. Software must rewrite the counter within a bounded interval. If the write comes too late, the counter steps down from 0x40 to 0x3F and a reset request is issued. If the write comes too soon, while the counter still sits above a programmable window value, a reset request is also issued.

One step before the late limit, the counter reaches exactly 0x40 and a warning flag is set. This gives an interrupt routine a last chance to rewrite the counter. Software clears the flag with a clear pulse, and an interrupt line follows the flag when warnings are enabled.

Once armed, the watchdog stays armed until the block's synchronous reset. The reset request is a one-cycle pulse intended for the chip's reset controller.

Top module: `window_watchdog`

## Requirements
- R1: After `rst`, the outputs are as follows: `cnt_o` is 0x7F; `active_o`, `flag_o`, `irq_o` and `wdg_rst_o` are 0. The window is 0x7F, the prescaler select is 0 and the warning interrupt is disabled.
- R2: While armed, `cnt_o` decreases by one every 2^(2+psel) clock cycles, where psel is the value of `cfg_psel`. A counter write restarts this interval, so the first step comes 2^(2+psel) cycles after the write edge.
- R3: A counter write (`cnt_wr`) loads `cnt_data` into the counter. The block becomes armed only if `cnt_enable` is 1. While not armed, the counter does not step. Once armed, `active_o` stays 1 until `rst`, whatever `cnt_enable` holds.
- R4: When the counter steps from 0x40 to 0x3F, `wdg_rst_o` is 1 for exactly the cycle after that edge. From that edge, `cnt_o` reads 0x3F.
- R5: A counter write while armed, with the pre-write counter strictly above the window value, gives a one-cycle `wdg_rst_o` pulse after the write edge. A write when the counter equals the window value gives no pulse. The written value is still loaded in both cases.
- R6: A counter write whose bit 6 is 0, made while armed or while arming, gives a one-cycle `wdg_rst_o` pulse after the write edge.
- R7: `flag_o` sets when the counter steps from 0x41 to 0x40. A `flag_clr` pulse clears it. If the flag is set and cleared in the same cycle, the set wins.
- R8: `irq_o` is 1 exactly when `flag_o` is 1 and the stored warning-interrupt enable (`cfg_irq_en`) is 1.
- R9: A counter write in the same cycle as a prescaler step takes priority. The counter is loaded and does not step. When the counter was 0x40, no expiry pulse occurs.
- R10: `cfg_wr` stores the window value, prescaler select and interrupt enable. The new values take effect from the next cycle; a counter write in the same cycle is compared against the old window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Store configuration fields |
| cfg_window | input | 7 | Window value; refreshes above it are too early |
| cfg_psel | input | 2 | Prescaler select, divide by 2^(2+psel) |
| cfg_irq_en | input | 1 | Warning interrupt enable |
| cnt_wr | input | 1 | Counter write (refresh) strobe |
| cnt_data | input | 7 | Value loaded into the counter |
| cnt_enable | input | 1 | Arm the watchdog with this write |
| flag_clr | input | 1 | Clear the warning flag |
| cnt_o | output | 7 | Current counter value |
| active_o | output | 1 | Watchdog armed |
| flag_o | output | 1 | Early-warning flag |
| irq_o | output | 1 | Early-warning interrupt request |
| wdg_rst_o | output | 1 | One-cycle reset request |

## Verification
The hardest situation to reach is a refresh that lands in the exact cycle in which the prescaler steps the counter out of 0x40. That case has to prove that the write wins and that no expiry pulse leaks out. A second hard case is a refresh exactly at and one above the window value. The bench tracks the prescaler phase in its own reference model and waits until the model reports the critical cycle before it raises the write. The boundary refreshes are aimed the same way. Constrained random phases then mix refreshes, configuration changes, flag clears and system resets against the same model.

// File: rtl/wwd_pkg.sv
package wwd_pkg;

    localparam int unsigned WWD_CNT_W         = 7;
    localparam int unsigned WWD_PSEL_W        = 2;
    localparam int unsigned WWD_DIV_BASE_LOG2 = 2;

    // what the counter does in a given cycle
    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_LOAD = 2'd1,
        CNT_STEP = 2'd2
    } wwd_cnt_op_e;

    // individual reasons for a reset request
    typedef struct packed {
        logic expire;     // stepped out of the lowest valid level
        logic early;      // refresh above the window
        logic low_write;  // refresh with the top bit clear
    } wwd_cause_t;

    // last prescaler count before a step, for a given select
    function automatic int unsigned wwd_div_last(int unsigned base_log2,
                                                 int unsigned sel);
        return (32'd1 << (base_log2 + sel)) - 32'd1;
    endfunction

    function automatic logic wwd_any_cause(wwd_cause_t c);
        return c.expire | c.early | c.low_write;
    endfunction

endpackage

// File: rtl/wwd_prescaler.sv
module wwd_prescaler
    import wwd_pkg::*;
#(
    parameter int unsigned PSEL_W        = WWD_PSEL_W,
    parameter int unsigned DIV_BASE_LOG2 = WWD_DIV_BASE_LOG2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              restart,
    input  logic [PSEL_W-1:0] psel,
    output logic              tick
);
    localparam int unsigned PRE_W = DIV_BASE_LOG2 + (1 << PSEL_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] last;

    always_comb begin
        last = PRE_W'(wwd_div_last(DIV_BASE_LOG2, 32'(psel)));
        tick = run && (pre_q >= last);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
        end else if (!run || restart || tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // R2: the prescaler never runs while the watchdog is idle
    a_r2_idle_prescaler: assert property (@(posedge clk) disable iff (rst)
        !run |=> (pre_q == '0));

endmodule

// File: rtl/wwd_counter.sv
module wwd_counter
    import wwd_pkg::*;
#(
    parameter int unsigned CNT_W = WWD_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             start,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             active,
    output logic             expire,
    output logic             warn
);
    localparam logic [CNT_W-1:0] LVL_EXPIRE = CNT_W'(1) << (CNT_W - 1);
    localparam logic [CNT_W-1:0] LVL_WARN   = LVL_EXPIRE + CNT_W'(1);
    localparam logic [CNT_W-1:0] LVL_MAX    = '1;

    wwd_cnt_op_e op;

    always_comb begin
        if (load)
            op = CNT_LOAD;
        else if (active && tick)
            op = CNT_STEP;
        else
            op = CNT_HOLD;
        expire = (op == CNT_STEP) && (cnt == LVL_EXPIRE);
        warn   = (op == CNT_STEP) && (cnt == LVL_WARN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= LVL_MAX;
            active <= 1'b0;
        end else begin
            case (op)
                CNT_LOAD: cnt <= load_val;
                CNT_STEP: cnt <= cnt - 1'b1;
                default:  cnt <= cnt;
            endcase
            active <= active | (load & start);
        end
    end

    // R3: once armed, only reset disarms
    a_r3_active_sticky: assert property (@(posedge clk) disable iff (rst)
        active |=> active);
    // R2: a step lowers the count by exactly one
    a_r2_step_by_one: assert property (@(posedge clk) disable iff (rst)
        (active && tick && !load) |=> (cnt == $past(cnt) - 1'b1));
    // R3: an idle counter holds without a write
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!active && !load) |=> $stable(cnt));

endmodule

// File: rtl/wwd_window.sv
module wwd_window
    import wwd_pkg::*;
#(
    parameter int unsigned CNT_W = WWD_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             start,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] window,
    input  logic             expire,
    output logic             wdg_rst
);
    wwd_cause_t cause;

    always_comb begin
        cause.expire    = expire;
        cause.early     = load && active && (cnt > window);
        cause.low_write = load && (active || start) && !load_val[CNT_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst)
            wdg_rst <= 1'b0;
        else
            wdg_rst <= wwd_any_cause(cause);
    end

    // R6: a write with the top bit clear while armed requests a reset
    a_r6_low_write: assert property (@(posedge clk) disable iff (rst)
        (load && active && !load_val[CNT_W-1]) |=> wdg_rst);
    // R5: a write at or below the window with a valid value is accepted
    a_r5_in_window_ok: assert property (@(posedge clk) disable iff (rst)
        (load && active && (cnt <= window) && load_val[CNT_W-1] && !expire)
            |=> !wdg_rst);

endmodule

// File: rtl/wwd_warnflag.sv
module wwd_warnflag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

    assign irq = flag & irq_en;

    // R7: set takes priority over clear
    a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
        set |=> flag);
    // R7: a clear without a set empties the flag
    a_r7_clear: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !flag);

endmodule

// File: rtl/window_watchdog.sv
module window_watchdog
    import wwd_pkg::*;
#(
    parameter int unsigned CNT_W         = WWD_CNT_W,
    parameter int unsigned PSEL_W        = WWD_PSEL_W,
    parameter int unsigned DIV_BASE_LOG2 = WWD_DIV_BASE_LOG2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [CNT_W-1:0]  cfg_window,
    input  logic [PSEL_W-1:0] cfg_psel,
    input  logic              cfg_irq_en,
    input  logic              cnt_wr,
    input  logic [CNT_W-1:0]  cnt_data,
    input  logic              cnt_enable,
    input  logic              flag_clr,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              active_o,
    output logic              flag_o,
    output logic              irq_o,
    output logic              wdg_rst_o
);
    localparam logic [CNT_W-1:0] LVL_EXPIRE = CNT_W'(1) << (CNT_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  window;
        logic [PSEL_W-1:0] psel;
        logic              irq_en;
    } cfg_t;

    cfg_t cfg_q;
    logic tick;
    logic expire;
    logic warn;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.window <= '1;
            cfg_q.psel   <= '0;
            cfg_q.irq_en <= 1'b0;
        end else if (cfg_wr) begin
            cfg_q.window <= cfg_window;
            cfg_q.psel   <= cfg_psel;
            cfg_q.irq_en <= cfg_irq_en;
        end
    end

    wwd_prescaler #(
        .PSEL_W        (PSEL_W),
        .DIV_BASE_LOG2 (DIV_BASE_LOG2)
    ) u_pre (
        .clk     (clk),
        .rst     (rst),
        .run     (active_o),
        .restart (cnt_wr),
        .psel    (cfg_q.psel),
        .tick    (tick)
    );

    wwd_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_wr),
        .load_val (cnt_data),
        .start    (cnt_enable),
        .tick     (tick),
        .cnt      (cnt_o),
        .active   (active_o),
        .expire   (expire),
        .warn     (warn)
    );

    wwd_window #(
        .CNT_W (CNT_W)
    ) u_win (
        .clk      (clk),
        .rst      (rst),
        .active   (active_o),
        .load     (cnt_wr),
        .load_val (cnt_data),
        .start    (cnt_enable),
        .cnt      (cnt_o),
        .window   (cfg_q.window),
        .expire   (expire),
        .wdg_rst  (wdg_rst_o)
    );

    wwd_warnflag u_flag (
        .clk    (clk),
        .rst    (rst),
        .set    (warn),
        .clr    (flag_clr),
        .irq_en (cfg_q.irq_en),
        .flag   (flag_o),
        .irq    (irq_o)
    );

    // R4: stepping out of the lowest level requests a reset
    a_r4_expiry: assert property (@(posedge clk) disable iff (rst)
        (active_o && tick && !cnt_wr && cnt_o == LVL_EXPIRE) |=> wdg_rst_o);
    // R5: a refresh above the window requests a reset
    a_r5_too_early: assert property (@(posedge clk) disable iff (rst)
        (active_o && cnt_wr && (cnt_o > cfg_q.window)) |=> wdg_rst_o);
    // R9: a write on a step cycle loads instead of stepping
    a_r9_write_wins: assert property (@(posedge clk) disable iff (rst)
        (cnt_wr && tick) |=> (cnt_o == $past(cnt_data)));
    // R7: the flag rises only on the step into the lowest level
    a_r7_flag_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_o) |-> (cnt_o == LVL_EXPIRE));

endmodule

// File: tb/sim_window_watchdog.sv
`timescale 1ns/1ps
module sim_window_watchdog;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_wr;
    logic [6:0] cfg_window;
    logic [1:0] cfg_psel;
    logic       cfg_irq_en;
    logic       cnt_wr;
    logic [6:0] cnt_data;
    logic       cnt_enable;
    logic       flag_clr;
    logic [6:0] cnt_o;
    logic       active_o;
    logic       flag_o;
    logic       irq_o;
    logic       wdg_rst_o;

    always #2.5 clk = ~clk;

    window_watchdog u0 (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_window(cfg_window),
        .cfg_psel(cfg_psel), .cfg_irq_en(cfg_irq_en), .cnt_wr(cnt_wr),
        .cnt_data(cnt_data), .cnt_enable(cnt_enable), .flag_clr(flag_clr),
        .cnt_o(cnt_o), .active_o(active_o), .flag_o(flag_o), .irq_o(irq_o),
        .wdg_rst_o(wdg_rst_o)
    );

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    done   = 0;
    string phase  = "R1";

    // reference model, built from the requirements
    logic [6:0] m_cnt, m_win;
    logic [1:0] m_psel;
    logic       m_act, m_flag, m_ien, m_rst;
    int         m_pre;

    function automatic int lim(logic [1:0] ps);
        return (1 << (2 + ps)) - 1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 7'h7F; m_win = 7'h7F; m_psel = 2'd0;
            m_act = 0; m_flag = 0; m_ien = 0; m_rst = 0; m_pre = 0;
        end else begin
            logic tk, fset, r;
            logic [6:0] nc;
            logic na;
            int np;
            tk = m_act && (m_pre >= lim(m_psel));
            fset = 0; r = 0; nc = m_cnt; na = m_act; np = 0;
            if (cnt_wr) begin
                if (m_act && m_cnt > m_win) r = 1;
                if ((m_act || cnt_enable) && !cnt_data[6]) r = 1;
                nc = cnt_data;
                if (cnt_enable) na = 1;
            end else if (tk) begin
                if (m_cnt == 7'h40) r = 1;
                if (m_cnt == 7'h41) fset = 1;
                nc = m_cnt - 7'd1;
            end else begin
                np = m_act ? m_pre + 1 : 0;
            end
            if (fset) m_flag = 1;
            else if (flag_clr) m_flag = 0;
            if (cfg_wr) begin
                m_win = cfg_window; m_psel = cfg_psel; m_ien = cfg_irq_en;
            end
            m_cnt = nc; m_act = na; m_pre = np; m_rst = r;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        chk({phase, " R2 cnt"},   cnt_o,     m_cnt);
        chk({phase, " R3 active"}, active_o, m_act);
        chk({phase, " R7 flag"},  flag_o,    m_flag);
        chk({phase, " R8 irq"},   irq_o,     m_flag & m_ien);
        chk({phase, " R4 reset"}, wdg_rst_o, m_rst);
    endtask

    task automatic do_reset();
        rst = 1; cyc(); cyc(); rst = 0;
    endtask

    task automatic set_cfg(logic [6:0] w, logic [1:0] ps, logic ie);
        cfg_wr = 1; cfg_window = w; cfg_psel = ps; cfg_irq_en = ie;
        cyc(); cfg_wr = 0;
    endtask

    task automatic wr_cnt(logic [6:0] d, logic en);
        cnt_wr = 1; cnt_data = d; cnt_enable = en;
        cyc(); cnt_wr = 0; cnt_enable = 0;
    endtask

    task automatic wait_model(logic [6:0] c, bit on_tick);
        for (int i = 0; i < 5000; i++) begin
            if (m_cnt == c && ((m_pre == lim(m_psel)) == on_tick)) break;
            cyc();
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: got %0d expected below 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; cfg_wr = 0; cfg_window = 0; cfg_psel = 0; cfg_irq_en = 0;
        cnt_wr = 0; cnt_data = 0; cnt_enable = 0; flag_clr = 0;
        void'($urandom(32'd20240611));
        cyc(); cyc(); cyc(); rst = 0;
        cyc();
        // R1: reset state
        chk("R1 cnt", cnt_o, 7'h7F);
        chk("R1 active", active_o, 0);
        chk("R1 outputs", {flag_o, irq_o, wdg_rst_o}, 0);

        // R3: load without arming, counter holds
        phase = "R3";
        wr_cnt(7'h55, 0);
        repeat (20) cyc();
        chk("R3 idle hold", cnt_o, 7'h55);
        chk("R3 not armed", active_o, 0);

        // R10 and R2: divide by 8, then five steps after 40 cycles
        phase = "R2";
        set_cfg(7'h7F, 2'd1, 1'b1);
        wr_cnt(7'h7F, 1);
        repeat (40) cyc();
        chk("R2 five steps", cnt_o, 7'h7A);

        // R3: a write without enable does not disarm
        phase = "R3";
        wr_cnt(7'h7F, 0);
        chk("R3 sticky", active_o, 1);

        // R7/R8: flag at 0x40, clear, then refresh in time
        phase = "R7";
        wait_model(7'h40, 0);
        chk("R7 flag set", flag_o, 1);
        chk("R8 irq with enable", irq_o, 1);
        flag_clr = 1; cyc(); flag_clr = 0;
        chk("R7 flag cleared", flag_o, 0);
        wr_cnt(7'h7F, 0);
        chk("R7 refresh in time no reset", wdg_rst_o, 0);

        // R5: refresh exactly at the window, then one above
        phase = "R5";
        set_cfg(7'h50, 2'd0, 1'b1);
        wr_cnt(7'h7F, 0);
        chk("R5 early refresh", wdg_rst_o, 1);
        cyc();
        chk("R5 single pulse", wdg_rst_o, 0);
        wait_model(7'h50, 0);
        wr_cnt(7'h7F, 0);
        chk("R5 at window ok", wdg_rst_o, 0);
        wait_model(7'h51, 0);
        wr_cnt(7'h7F, 0);
        chk("R5 one above window", wdg_rst_o, 1);
        chk("R5 value loaded", cnt_o, 7'h7F);

        // R6: arming with bit 6 clear
        phase = "R6";
        do_reset();
        wr_cnt(7'h3F, 1);
        chk("R6 low write", wdg_rst_o, 1);

        // R4 and R8: expiry with interrupt disabled
        phase = "R4";
        do_reset();
        wr_cnt(7'h7F, 1);
        for (int i = 0; i < 5000 && !wdg_rst_o; i++) cyc();
        chk("R4 expiry pulse", wdg_rst_o, 1);
        chk("R4 count after expiry", cnt_o, 7'h3F);
        chk("R8 irq masked", irq_o, 0);
        cyc();
        chk("R4 pulse one cycle", wdg_rst_o, 0);

        // R9: write on the exact step cycle out of 0x40
        phase = "R9";
        do_reset();
        wr_cnt(7'h7F, 1);
        wait_model(7'h40, 1);
        wr_cnt(7'h7E, 0);
        chk("R9 no expiry", wdg_rst_o, 0);
        chk("R9 write wins", cnt_o, 7'h7E);

        // constrained random mix
        phase = "random";
        do_reset();
        for (int i = 0; i < 6000; i++) begin
            if (wdg_rst_o) begin
                do_reset();
                continue;
            end
            cfg_wr     = ($urandom_range(0, 99) < 2);
            cfg_window = 7'($urandom_range(7'h40, 7'h7F));
            cfg_psel   = 2'($urandom_range(0, 1));
            cfg_irq_en = 1'($urandom_range(0, 1));
            cnt_wr     = ($urandom_range(0, 63) == 0);
            cnt_data   = ($urandom_range(0, 3) == 0) ? 7'($urandom) : 7'h7F;
            cnt_enable = 1'($urandom_range(0, 1));
            flag_clr   = ($urandom_range(0, 15) == 0);
            cyc();
        end
        cfg_wr = 0; cnt_wr = 0; flag_clr = 0;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule